// File: doc/BRIEF.md
# LPC Bus Cycle Monitor

A passive observer for a Low Pin Count bus. On every rising edge of the bus clock it samples the active-low frame strobe and the four-bit multiplexed address/data lines. From these samples it follows target I/O and memory cycles through their phases. It never drives the bus. Each completed cycle is reported as one record: start kind, address space, direction, address, data byte and the SYNC code that ended the wait.

The monitor runs alongside the bus and does not take part in it. Protocol irregularities are reported on a warning strobe with a three-bit code:

- a turn-around clock that does not read all ones;
- a reserved SYNC code;
- a reserved cycle type;
- an abort released too early;
- a wait that runs too long.

A host abort is reported on its own strobe, and the cycle in progress is dropped. DMA cycles, bus-master grants and firmware cycles are recognised only far enough to step aside. The bus reset pin clears the monitor synchronously, alongside the asynchronous system reset.

Top module: `lpc_cycle_monitor`

## Requirements
- R1: Asynchronous `rst_ni` low, or `bus_rst_ni` low at a clock edge, returns the monitor to idle with all strobes low. A cycle cut by a reset yields no record, even if its remaining nibbles follow.
- R2: A cycle opens when `frame_ni` is sampled low while idle. The start code is the `lad_i` value on the last low clock before `frame_ni` returns high. Code 0000 (target) and code 0101 (TPM, `rec_tpm_o`=1) are tracked. Every other code, including the firmware codes 1101 and 1110, ends tracking without a record or warning.
- R3: The nibble on the first high-frame clock is the cycle type. Bits [3:2] select the space: 00 is I/O (`rec_mem_o`=0) and 01 is memory (`rec_mem_o`=1). Bit 1 set means write, and bit 0 is ignored. Type 10xx (DMA) ends tracking silently. Type 11xx gives warning code 3 and ends tracking.
- R4: Address nibbles arrive most significant first. There are 4 for I/O, which leaves `rec_addr_o[31:16]` zero, and 8 for memory.
- R5: A read runs address, two turn-around clocks, SYNC, data, two turn-around clocks. A write runs address, data, two turn-around clocks, SYNC, two turn-around clocks. The data byte takes two clocks, low nibble first.
- R6: SYNC codes 0101 and 0110 mean wait. Codes 0000, 1001 and 1010 end the SYNC phase and appear on `rec_sync_o`. Any other code gives warning code 2, and is also taken as the final SYNC.
- R7: Every turn-around clock whose nibble is not 1111 gives warning code 1. Decoding continues.
- R8: `rec_valid_o` is high for exactly the one clock after the last turn-around sample, with all record fields valid.
- R9: While a cycle is past its cycle-type nibble, `frame_ni` low on two consecutive samples is an abort. `abort_o` pulses on the clock after the second low sample and no record follows. The monitor then expects two more low samples. A high sample before that gives warning code 4. In both cases the monitor returns to idle.
- R10: `WAIT_LIMIT` consecutive wait codes give warning code 5 on the clock after the last of them, and the monitor returns to idle with no record. Fewer waits followed by a ready code complete normally.
- R11: `warn_valid_o` is high for one clock, the clock after the offending sample, with the code on `warn_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_ni | input | 1 | Bus reset pin, synchronous, active low |
| frame_ni | input | 1 | Bus frame strobe, active low |
| lad_i | input | 4 | Multiplexed address/data/control nibble |
| rec_valid_o | output | 1 | One-clock record strobe |
| rec_tpm_o | output | 1 | Record was opened with the TPM start code |
| rec_mem_o | output | 1 | 1 memory cycle, 0 I/O cycle |
| rec_write_o | output | 1 | 1 write, 0 read |
| rec_addr_o | output | 32 | Decoded address |
| rec_data_o | output | 8 | Data byte |
| rec_sync_o | output | 4 | SYNC code that ended the wait |
| warn_valid_o | output | 1 | One-clock warning strobe |
| warn_code_o | output | 3 | Warning code: 1 turn-around, 2 reserved SYNC, 3 reserved type, 4 short abort, 5 wait timeout |
| abort_o | output | 1 | One-clock host abort strobe |

## Verification
The properties assume the inputs are settled binary values at each rising edge. They also assume the bus reset is the only way a cycle is cut short, apart from the frame strobe. The stimulus changes inputs only on falling edges and always drives a defined nibble, all ones when the bus would float. The random cycles keep the frame strobe high between start and end, so that no unintended abort appears. Aborts, early releases and timeouts come only from the directed cases. `WAIT_LIMIT` is reduced to keep the timeout cases short.

// File: rtl/lpc_mon_pkg.sv
package lpc_mon_pkg;
  localparam int NIB_W  = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 32;
  localparam int IO_NIBS  = 4;
  localparam int MEM_NIBS = ADDR_W / NIB_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_TAR1, ST_SYNC, ST_DATA, ST_TAR2, ST_ABORT
  } mon_state_e;

  typedef enum logic [2:0] {
    WARN_NONE        = 3'd0,
    WARN_TAR         = 3'd1,
    WARN_SYNC_RSVD   = 3'd2,
    WARN_TYPE_RSVD   = 3'd3,
    WARN_ABORT_SHORT = 3'd4,
    WARN_WAIT_TMO    = 3'd5
  } warn_code_e;

  localparam logic [NIB_W-1:0] START_TARGET = 4'h0;
  localparam logic [NIB_W-1:0] START_TPM    = 4'h5;
  localparam logic [NIB_W-1:0] NIB_IDLE     = 4'hF;
  localparam logic [NIB_W-1:0] SYNC_READY   = 4'h0;
  localparam logic [NIB_W-1:0] SYNC_SHORT   = 4'h5;
  localparam logic [NIB_W-1:0] SYNC_LONG    = 4'h6;
  localparam logic [NIB_W-1:0] SYNC_MORE    = 4'h9;
  localparam logic [NIB_W-1:0] SYNC_ERR     = 4'hA;
endpackage

// File: rtl/lpc_sync_class.sv
module lpc_sync_class
  import lpc_mon_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic             wait_o,
  output logic             final_o,
  output logic             rsvd_o
);
  always_comb begin
    wait_o  = (nib_i == SYNC_SHORT) || (nib_i == SYNC_LONG);
    final_o = (nib_i == SYNC_READY) || (nib_i == SYNC_MORE) || (nib_i == SYNC_ERR);
    rsvd_o  = !wait_o && !final_o;
  end
endmodule

// File: rtl/lpc_frame_watch.sv
module lpc_frame_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic frame_ni,
  input  logic in_cycle_i,
  output logic hit_o
);
  logic frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frame_q <= 1'b1;
    else if (clr_i) frame_q <= 1'b1;
    else            frame_q <= frame_ni;
  end

  // second consecutive low sample inside a cycle
  assign hit_o = in_cycle_i && !frame_ni && !frame_q;
endmodule

// File: rtl/lpc_wait_timer.sv
module lpc_wait_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wait_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = wait_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !wait_i)  cnt_q <= '0;
    else if (!expire_o)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpc_cycle_monitor.sv
module lpc_cycle_monitor
  import lpc_mon_pkg::*;
#(
  parameter int WAIT_LIMIT = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_rst_ni,
  input  logic        frame_ni,
  input  logic [3:0]  lad_i,
  output logic        rec_valid_o,
  output logic        rec_tpm_o,
  output logic        rec_mem_o,
  output logic        rec_write_o,
  output logic [31:0] rec_addr_o,
  output logic [7:0]  rec_data_o,
  output logic [3:0]  rec_sync_o,
  output logic        warn_valid_o,
  output logic [2:0]  warn_code_o,
  output logic        abort_o
);
  localparam logic [2:0] IO_LAST  = 3'(IO_NIBS - 1);
  localparam logic [2:0] MEM_LAST = 3'(MEM_NIBS - 1);

  mon_state_e        state_q;
  logic [2:0]        cnt_q;
  logic [NIB_W-1:0]  start_q;
  logic              tpm_q, mem_q, write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [NIB_W-1:0]  sync_q;
  logic              rec_q, warn_q, abort_q;
  warn_code_e        code_q;

  logic in_cycle, abort_hit, bus_clr;
  logic sync_wait, sync_final, sync_rsvd, wait_tmo;
  logic tar_bad;

  assign bus_clr  = !bus_rst_ni;
  assign in_cycle = (state_q == ST_ADDR) || (state_q == ST_TAR1) || (state_q == ST_SYNC)
                 || (state_q == ST_DATA) || (state_q == ST_TAR2);
  assign tar_bad  = (lad_i != NIB_IDLE);

  lpc_frame_watch i_frame_watch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (bus_clr),
    .frame_ni   (frame_ni),
    .in_cycle_i (in_cycle),
    .hit_o      (abort_hit)
  );

  lpc_sync_class i_sync_class (
    .nib_i   (lad_i),
    .wait_o  (sync_wait),
    .final_o (sync_final),
    .rsvd_o  (sync_rsvd)
  );

  lpc_wait_timer #(.LIMIT(WAIT_LIMIT)) i_wait_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (bus_clr),
    .wait_i   ((state_q == ST_SYNC) && sync_wait),
    .expire_o (wait_tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      start_q <= '0;
      tpm_q   <= 1'b0;
      mem_q   <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      sync_q  <= '0;
      rec_q   <= 1'b0;
      warn_q  <= 1'b0;
      abort_q <= 1'b0;
      code_q  <= WARN_NONE;
    end else if (bus_clr) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rec_q   <= 1'b0;
      warn_q  <= 1'b0;
      abort_q <= 1'b0;
      code_q  <= WARN_NONE;
    end else begin
      rec_q   <= 1'b0;
      warn_q  <= 1'b0;
      abort_q <= 1'b0;
      if (abort_hit) begin
        state_q <= ST_ABORT;
        cnt_q   <= '0;
        abort_q <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (!frame_ni) begin
              state_q <= ST_START;
              start_q <= lad_i;
            end
          end
          ST_START: begin
            if (!frame_ni) begin
              start_q <= lad_i;
            end else if (start_q == START_TARGET || start_q == START_TPM) begin
              tpm_q <= (start_q == START_TPM);
              unique case (lad_i[3:2])
                2'b11: begin
                  warn_q  <= 1'b1;
                  code_q  <= WARN_TYPE_RSVD;
                  state_q <= ST_IDLE;
                end
                2'b10: state_q <= ST_IDLE;
                default: begin
                  mem_q   <= lad_i[2];
                  write_q <= lad_i[1];
                  addr_q  <= '0;
                  cnt_q   <= '0;
                  state_q <= ST_ADDR;
                end
              endcase
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_ADDR: begin
            addr_q <= {addr_q[ADDR_W-NIB_W-1:0], lad_i};
            if (cnt_q == (mem_q ? MEM_LAST : IO_LAST)) begin
              cnt_q   <= '0;
              state_q <= write_q ? ST_DATA : ST_TAR1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_TAR1: begin
            if (tar_bad) begin
              warn_q <= 1'b1;
              code_q <= WARN_TAR;
            end
            if (cnt_q[0]) begin
              cnt_q   <= '0;
              state_q <= ST_SYNC;
            end else begin
              cnt_q <= 3'd1;
            end
          end
          ST_SYNC: begin
            if (sync_wait) begin
              if (wait_tmo) begin
                warn_q  <= 1'b1;
                code_q  <= WARN_WAIT_TMO;
                state_q <= ST_IDLE;
              end
            end else begin
              sync_q <= lad_i;
              if (sync_rsvd) begin
                warn_q <= 1'b1;
                code_q <= WARN_SYNC_RSVD;
              end
              cnt_q   <= '0;
              state_q <= write_q ? ST_TAR2 : ST_DATA;
            end
          end
          ST_DATA: begin
            // low nibble first
            if (!cnt_q[0]) begin
              data_q[NIB_W-1:0] <= lad_i;
              cnt_q <= 3'd1;
            end else begin
              data_q[DATA_W-1:NIB_W] <= lad_i;
              cnt_q   <= '0;
              state_q <= write_q ? ST_TAR1 : ST_TAR2;
            end
          end
          ST_TAR2: begin
            if (tar_bad) begin
              warn_q <= 1'b1;
              code_q <= WARN_TAR;
            end
            if (cnt_q[0]) begin
              cnt_q   <= '0;
              rec_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= 3'd1;
            end
          end
          ST_ABORT: begin
            if (frame_ni) begin
              warn_q  <= 1'b1;
              code_q  <= WARN_ABORT_SHORT;
              state_q <= ST_IDLE;
            end else if (cnt_q[0]) begin
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= 3'd1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // sync_final is implied by !sync_wait && !sync_rsvd; kept for clarity of decode
  logic unused_final;
  assign unused_final = sync_final;

  assign rec_valid_o  = rec_q;
  assign rec_tpm_o    = tpm_q;
  assign rec_mem_o    = mem_q;
  assign rec_write_o  = write_q;
  assign rec_addr_o   = addr_q;
  assign rec_data_o   = data_q;
  assign rec_sync_o   = sync_q;
  assign warn_valid_o = warn_q;
  assign warn_code_o  = code_q;
  assign abort_o      = abort_q;
endmodule

// File: rtl/lpc_mon_checker.sv
module lpc_mon_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_rst_ni,
  input logic        frame_ni,
  input logic [3:0]  lad_i,
  input logic        rec_valid_o,
  input logic        rec_mem_o,
  input logic [31:0] rec_addr_o,
  input logic [3:0]  rec_sync_o,
  input logic        warn_valid_o,
  input logic [2:0]  warn_code_o,
  input logic        abort_o
);
  assert_bus_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_ni |=> (!rec_valid_o && !warn_valid_o && !abort_o));

  assert_reserved_type_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    (warn_valid_o && warn_code_o == 3'd3) |-> ($past(lad_i[3:2]) == 2'b11));

  assert_io_addr_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    (rec_valid_o && !rec_mem_o) |-> (rec_addr_o[31:16] == 16'h0));

  assert_sync_not_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    rec_valid_o |-> (rec_sync_o != 4'h5 && rec_sync_o != 4'h6));

  assert_reserved_sync_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    (warn_valid_o && warn_code_o == 3'd2) |->
      !($past(lad_i) inside {4'h0, 4'h5, 4'h6, 4'h9, 4'hA}));

  assert_record_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    rec_valid_o |=> !rec_valid_o);

  assert_abort_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    abort_o |-> (!$past(frame_ni) && !$past(frame_ni, 2)));

  assert_abort_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    abort_o |=> !abort_o);

  assert_abort_no_record_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    abort_o |-> !rec_valid_o);

  assert_timeout_on_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    (warn_valid_o && warn_code_o == 3'd5) |-> ($past(lad_i) == 4'h5 || $past(lad_i) == 4'h6));

  assert_warn_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    warn_valid_o |-> (warn_code_o inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}));
endmodule

bind lpc_cycle_monitor lpc_mon_checker i_lpc_mon_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_rst_ni   (bus_rst_ni),
  .frame_ni     (frame_ni),
  .lad_i        (lad_i),
  .rec_valid_o  (rec_valid_o),
  .rec_mem_o    (rec_mem_o),
  .rec_addr_o   (rec_addr_o),
  .rec_sync_o   (rec_sync_o),
  .warn_valid_o (warn_valid_o),
  .warn_code_o  (warn_code_o),
  .abort_o      (abort_o)
);

// File: tb/test_lpc_cycle_monitor.sv
module test_lpc_cycle_monitor;
  localparam int LIMIT = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rst_ni = 1'b1;
  logic        frame_ni = 1'b1;
  logic [3:0]  lad = 4'hF;
  logic        rec_valid, rec_tpm, rec_mem, rec_write, warn_valid, abort;
  logic [31:0] rec_addr;
  logic [7:0]  rec_data;
  logic [3:0]  rec_sync;
  logic [2:0]  warn_code;

  int tests = 0, fails = 0;
  int tick_no = 0, rec_cnt = 0, rec_at = -1, warn_cnt = 0, abort_cnt = 0, abort_at = -1;
  logic [2:0]  last_warn;
  logic        s_tpm, s_mem, s_write;
  logic [31:0] s_addr;
  logic [7:0]  s_data;
  logic [3:0]  s_sync;

  always #10 clk = ~clk;

  lpc_cycle_monitor #(.WAIT_LIMIT(LIMIT)) i_lpc_cycle_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni), .frame_ni(frame_ni), .lad_i(lad),
    .rec_valid_o(rec_valid), .rec_tpm_o(rec_tpm), .rec_mem_o(rec_mem), .rec_write_o(rec_write),
    .rec_addr_o(rec_addr), .rec_data_o(rec_data), .rec_sync_o(rec_sync),
    .warn_valid_o(warn_valid), .warn_code_o(warn_code), .abort_o(abort)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    rec_cnt = 0; rec_at = -1; warn_cnt = 0; abort_cnt = 0; abort_at = -1; last_warn = 3'd0;
  endtask

  // drive at falling edge, return at next falling edge with outputs of that sample
  task automatic tick(input logic f, input logic [3:0] l);
    frame_ni = f; lad = l;
    @(posedge clk);
    @(negedge clk);
    tick_no++;
    if (rec_valid) begin
      rec_cnt++; rec_at = tick_no;
      s_tpm = rec_tpm; s_mem = rec_mem; s_write = rec_write;
      s_addr = rec_addr; s_data = rec_data; s_sync = rec_sync;
    end
    if (warn_valid) begin warn_cnt++; last_warn = warn_code; end
    if (abort) begin abort_cnt++; abort_at = tick_no; end
  endtask

  task automatic run_cycle(input logic [3:0] start_code, input bit lead_en, input logic [3:0] lead,
                           input logic [3:0] ct, input logic [31:0] addr, input logic [7:0] data,
                           input int nwait, input logic [3:0] wcode, input logic [3:0] sfin,
                           input bit tar_bad);
    int nibs;
    nibs = ct[2] ? 8 : 4;
    clear_obs();
    tick(1'b1, 4'hF);
    if (lead_en) tick(1'b0, lead);
    tick(1'b0, start_code);
    tick(1'b1, ct);
    for (int i = 0; i < nibs; i++) tick(1'b1, addr[(nibs-1-i)*4 +: 4]);
    if (ct[1]) begin
      tick(1'b1, data[3:0]); tick(1'b1, data[7:4]);
      tick(1'b1, tar_bad ? 4'h7 : 4'hF); tick(1'b1, 4'hF);
      for (int i = 0; i < nwait; i++) tick(1'b1, wcode);
      tick(1'b1, sfin);
    end else begin
      tick(1'b1, tar_bad ? 4'h7 : 4'hF); tick(1'b1, 4'hF);
      for (int i = 0; i < nwait; i++) tick(1'b1, wcode);
      tick(1'b1, sfin);
      tick(1'b1, data[3:0]); tick(1'b1, data[7:4]);
    end
    tick(1'b1, 4'hF); tick(1'b1, 4'hF);
  endtask

  task automatic check_record(input string req, input bit tpm, input logic [3:0] ct,
                              input logic [31:0] addr, input logic [7:0] data, input logic [3:0] sfin);
    logic [31:0] ea;
    ea = ct[2] ? addr : {16'h0, addr[15:0]};
    chk(rec_cnt == 1 && rec_at == tick_no, {req, " R8 record strobe on last turn-around"},
        64'(rec_at), 64'(tick_no));
    chk(s_addr == ea && s_mem == ct[2] && s_write == ct[1] && s_tpm == tpm,
        {req, " R4 R5 address/kind"}, {s_tpm, s_mem, s_write, s_addr}, {tpm, ct[2], ct[1], ea});
    chk(s_data == data && s_sync == sfin, {req, " R5 R6 data/sync"}, {s_data, s_sync}, {data, sfin});
  endtask

  logic [3:0] sync_pick [3] = '{4'h0, 4'h9, 4'hA};

  initial begin
    int seed;
    seed = $urandom(32'h1a2b3c);
    clear_obs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rec_valid && !warn_valid && !abort, "R1 strobes low in reset",
        {rec_valid, warn_valid, abort}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // random target/TPM I/O and memory cycles
    for (int n = 0; n < 40; n++) begin
      logic [3:0] ct, sf, st;
      logic [31:0] a;
      logic [7:0] d;
      int nw;
      ct = {1'b0, 1'($urandom), 1'($urandom), 1'($urandom)};
      a = $urandom; d = 8'($urandom);
      nw = $urandom_range(0, 5);
      sf = sync_pick[$urandom_range(0, 2)];
      st = ($urandom_range(0, 1) == 1) ? 4'h5 : 4'h0;
      run_cycle(st, 1'b0, 4'h0, ct, a, d, nw, ($urandom_range(0, 1) == 1) ? 4'h5 : 4'h6, sf, 1'b0);
      check_record("R2 R3 random", st == 4'h5, ct, a, d, sf);
      chk(warn_cnt == 0 && abort_cnt == 0, "R7 R11 clean random cycle quiet", warn_cnt, 0);
    end

    // R2 multi-clock start, last code counts
    run_cycle(4'h0, 1'b1, 4'h3, 4'h4, 32'hDEAD_BEEF, 8'h5A, 0, 4'h5, 4'h0, 1'b0);
    check_record("R2 long frame", 1'b0, 4'h4, 32'hDEAD_BEEF, 8'h5A, 4'h0);
    run_cycle(4'h3, 1'b1, 4'h0, 4'h4, 32'h1234_5678, 8'h11, 0, 4'h5, 4'h0, 1'b0);
    chk(rec_cnt == 0 && warn_cnt == 0, "R2 last start code not target", rec_cnt, 0);
    run_cycle(4'hD, 1'b0, 4'h0, 4'h4, 32'h1234_5678, 8'h11, 0, 4'h5, 4'h0, 1'b0);
    chk(rec_cnt == 0 && warn_cnt == 0, "R2 firmware start ignored", rec_cnt, 0);

    // R3 type decode
    run_cycle(4'h0, 1'b0, 4'h0, 4'h7, 32'hCAFE_F00D, 8'hC3, 1, 4'h6, 4'h9, 1'b0);
    check_record("R3 bit0 ignored", 1'b0, 4'h7, 32'hCAFE_F00D, 8'hC3, 4'h9);
    run_cycle(4'h0, 1'b0, 4'h0, 4'h8, 32'h0, 8'h0, 0, 4'h5, 4'h0, 1'b0);
    chk(rec_cnt == 0 && warn_cnt == 0, "R3 DMA type silent", {rec_cnt, warn_cnt}, 0);
    run_cycle(4'h0, 1'b0, 4'h0, 4'hC, 32'h0, 8'h0, 0, 4'h5, 4'h0, 1'b0);
    chk(rec_cnt == 0 && warn_cnt == 1 && last_warn == 3'd3, "R3 reserved type warns",
        {rec_cnt, warn_cnt, last_warn}, {32'd0, 32'd1, 3'd3});

    // R4 I/O upper address bits zero
    run_cycle(4'h0, 1'b0, 4'h0, 4'h0, 32'hFFFF_ABCD, 8'h77, 0, 4'h5, 4'h0, 1'b0);
    chk(rec_cnt == 1 && s_addr == 32'h0000_ABCD, "R4 I/O address 16 bits", s_addr, 32'h0000_ABCD);

    // R6 reserved sync
    run_cycle(4'h0, 1'b0, 4'h0, 4'h4, 32'h0102_0304, 8'h9E, 2, 4'h5, 4'h3, 1'b0);
    check_record("R6 reserved sync", 1'b0, 4'h4, 32'h0102_0304, 8'h9E, 4'h3);
    chk(warn_cnt == 1 && last_warn == 3'd2, "R6 reserved sync warns", {warn_cnt, last_warn}, {32'd1, 3'd2});

    // R7 bad turn-around on both directions
    run_cycle(4'h0, 1'b0, 4'h0, 4'h6, 32'h0BAD_7A50, 8'h42, 0, 4'h5, 4'h0, 1'b1);
    check_record("R7 write bad TAR", 1'b0, 4'h6, 32'h0BAD_7A50, 8'h42, 4'h0);
    chk(warn_cnt == 1 && last_warn == 3'd1, "R7 TAR warning", {warn_cnt, last_warn}, {32'd1, 3'd1});
    run_cycle(4'h0, 1'b0, 4'h0, 4'h0, 32'h0000_1F2E, 8'h24, 0, 4'h5, 4'h0, 1'b1);
    chk(rec_cnt == 1 && warn_cnt == 1 && last_warn == 3'd1, "R7 read bad TAR",
        {rec_cnt, warn_cnt, last_warn}, {32'd1, 32'd1, 3'd1});

    // R9 full abort during address phase
    clear_obs();
    tick(1'b1, 4'hF); tick(1'b0, 4'h0); tick(1'b1, 4'h4);
    tick(1'b1, 4'h1); tick(1'b1, 4'h2);
    tick(1'b0, 4'hF);
    tick(1'b0, 4'hF);
    chk(abort_cnt == 1 && abort_at == tick_no, "R9 abort strobe timing", abort_at, tick_no);
    tick(1'b0, 4'hF); tick(1'b0, 4'hF); tick(1'b1, 4'hF);
    for (int i = 0; i < 12; i++) tick(1'b1, 4'h0);
    chk(rec_cnt == 0 && warn_cnt == 0 && abort_cnt == 1, "R9 full abort quiet",
        {rec_cnt, warn_cnt, abort_cnt}, {32'd0, 32'd0, 32'd1});
    // monitor is idle again and decodes the next cycle
    run_cycle(4'h0, 1'b0, 4'h0, 4'h2, 32'h0000_0060, 8'hA5, 0, 4'h5, 4'h0, 1'b0);
    check_record("R9 after abort", 1'b0, 4'h2, 32'h0000_0060, 8'hA5, 4'h0);

    // R9 abort released early, during SYNC wait
    clear_obs();
    tick(1'b1, 4'hF); tick(1'b0, 4'h0); tick(1'b1, 4'h0);
    for (int i = 0; i < 4; i++) tick(1'b1, 4'h3);
    tick(1'b1, 4'hF); tick(1'b1, 4'hF); tick(1'b1, 4'h6);
    tick(1'b0, 4'h6); tick(1'b0, 4'h6); tick(1'b0, 4'hF); tick(1'b1, 4'hF);
    chk(abort_cnt == 1 && warn_cnt == 1 && last_warn == 3'd4 && rec_cnt == 0,
        "R9 short abort warns", {abort_cnt, warn_cnt, last_warn}, {32'd1, 32'd1, 3'd4});

    // R10 wait timeout and just-below limit
    run_cycle(4'h0, 1'b0, 4'h0, 4'h4, 32'h5555_AAAA, 8'h01, LIMIT, 4'h6, 4'h0, 1'b0);
    chk(rec_cnt == 0 && warn_cnt == 1 && last_warn == 3'd5, "R10 timeout at limit",
        {rec_cnt, warn_cnt, last_warn}, {32'd0, 32'd1, 3'd5});
    run_cycle(4'h0, 1'b0, 4'h0, 4'h4, 32'h5555_AAAA, 8'h01, LIMIT - 1, 4'h6, 4'h0, 1'b0);
    check_record("R10 below limit", 1'b0, 4'h4, 32'h5555_AAAA, 8'h01, 4'h0);
    chk(warn_cnt == 0, "R10 below limit no warning", warn_cnt, 0);

    // R1 bus reset mid-cycle
    clear_obs();
    tick(1'b1, 4'hF); tick(1'b0, 4'h0); tick(1'b1, 4'h4);
    for (int i = 0; i < 3; i++) tick(1'b1, 4'h8);
    bus_rst_ni = 1'b0;
    tick(1'b1, 4'h8);
    chk(!rec_valid && !warn_valid && !abort, "R1 bus reset strobes low", {rec_valid, warn_valid, abort}, 0);
    bus_rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b1, 4'h8);
    tick(1'b1, 4'hF); tick(1'b1, 4'hF); tick(1'b1, 4'h0);
    tick(1'b1, 4'h1); tick(1'b1, 4'h2); tick(1'b1, 4'hF); tick(1'b1, 4'hF);
    chk(rec_cnt == 0 && warn_cnt == 0, "R1 cut cycle gives no record", {rec_cnt, warn_cnt}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", tick_no);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule